// File: doc/BRIEF.md
# BCD Decimal Adjust Unit

This unit turns a binary accumulator into a valid decimal result after an addition or a subtraction. It takes the low byte and the high byte of the accumulator, together with the carry and auxiliary-carry flags left by that arithmetic. It then applies one of four decimal corrections, chosen by a two-bit mode. Two modes handle packed digits (two decimal digits in one byte). The other two handle unpacked digits (one digit per byte, with the tens carried into the high byte).

All corrections are combinational. A single register stage holds the result, so the corrected bytes and flags are valid one clock after the request. The surrounding datapath supplies the prior sign, zero and parity flags so that they can pass through unchanged in the modes that must not alter them. Loading the accumulator and doing the original add or subtract belong to other blocks.

Top module: `dec_adjust_unit`

## Requirements
- R1: The mode is coded 2'b00 packed-add and 2'b01 packed-subtract. In these modes, when the incoming AF is 1 or the low nibble of AL exceeds 9, AL becomes AL+0x06 (add) or AL-0x06 (subtract) modulo 256, and AF out is 1.
- R2: In the packed modes, CF out is 1 whenever CF in is 1. It is also 1 when the first correction fired and its 9-bit result had bit 8 set (add above 0xFF, or subtract below zero).
- R3: The second packed test compares the AL already changed by the first correction. When the carry from R2 is 1 or that AL exceeds 0x9F, AL gets a further +0x60 (add) or -0x60 (subtract) modulo 256 and CF out is 1.
- R4: In the packed modes, when the first correction does not fire, AF out equals AF in.
- R5: In the packed modes, SF out is bit 7 of the final AL. ZF out is 1 when the final AL is zero. PF out is 1 when the final AL has an even number of set bits. AH is returned unchanged.
- R6: The mode is coded 2'b10 unpacked-add and 2'b11 unpacked-subtract. In these modes, when AF in is 1 or the low nibble of AL exceeds 9, AL moves by +6 or -6 and AH moves by +1 or -1, and both AF out and CF out are 1.
- R7: In the unpacked modes, when that test fails, AF out and CF out are 0 whatever CF in was, and AH is unchanged.
- R8: In the unpacked modes, bits 7:4 of AL out are always 0.
- R9: In the unpacked modes, SF, ZF and PF out equal the values presented on their inputs.
- R10: The result and out_valid appear on the first rising edge after a cycle with in_valid high. out_valid is low in any cycle that does not follow such a request, and every output is 0 after reset.
- R11: All byte arithmetic wraps modulo 256, for example AH 0xFF plus one gives 0x00 and AH 0x00 minus one gives 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe; the inputs are captured in this cycle |
| mode | input | 2 | Correction select: 00 packed add, 01 packed sub, 10 unpacked add, 11 unpacked sub |
| al_i | input | 8 | Accumulator low byte |
| ah_i | input | 8 | Accumulator high byte |
| cf_i | input | 1 | Carry flag left by the arithmetic |
| af_i | input | 1 | Auxiliary-carry flag left by the arithmetic |
| sf_i | input | 1 | Prior sign flag, passed through in unpacked modes |
| zf_i | input | 1 | Prior zero flag, passed through in unpacked modes |
| pf_i | input | 1 | Prior parity flag, passed through in unpacked modes |
| out_valid | output | 1 | High one cycle after a request |
| al_o | output | 8 | Corrected low byte |
| ah_o | output | 8 | Corrected high byte |
| cf_o | output | 1 | New carry flag |
| af_o | output | 1 | New auxiliary-carry flag |
| sf_o | output | 1 | New sign flag |
| zf_o | output | 1 | New zero flag |
| pf_o | output | 1 | New parity flag |

## Verification
Every output of this unit is due exactly one rising edge after the cycle in which in_valid was high, and out_valid marks that cycle. The driver applies a request at a falling edge and records the expected bytes and flags in a queue at the same moment. The monitor compares the outputs only at a falling edge where out_valid is high, which is half a period after the register stage has loaded. Because the queue is strictly in order, back-to-back requests line up one to one with the results, and a result with no expectation waiting, or an expectation that is never served, counts as a failure.

// File: rtl/dadj_pkg.sv
package dadj_pkg;

  typedef enum logic [1:0] {
    ADJ_PK_ADD = 2'b00,
    ADJ_PK_SUB = 2'b01,
    ADJ_UN_ADD = 2'b10,
    ADJ_UN_SUB = 2'b11
  } adj_mode_e;

endpackage

// File: rtl/dadj_packed.sv
// Two chained corrections for packed digits; the second test sees the
// byte already changed by the first.
module dadj_packed #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_lo,
  input  logic              sub_sel,
  input  logic              carry_in,
  input  logic              aux_in,
  output logic [DATA_W-1:0] acc_out,
  output logic              carry_out,
  output logic              aux_out
);

  localparam int                LO_W       = DATA_W / 2;
  localparam logic [LO_W-1:0]   DIGIT_MAX  = LO_W'(9);
  localparam logic [DATA_W:0]   LOW_FIX    = (DATA_W+1)'(6);
  localparam logic [DATA_W-1:0] HIGH_FIX   = DATA_W'(6) << LO_W;
  localparam logic [DATA_W-1:0] HIGH_LIMIT = (DATA_W'(9) << LO_W) | DATA_W'((1 << LO_W) - 1);

  logic              low_fire;
  logic [DATA_W:0]   low_sum;
  logic [DATA_W-1:0] mid_val;
  logic              mid_carry;
  logic              high_fire;

  always_comb begin
    low_fire  = aux_in || (acc_lo[LO_W-1:0] > DIGIT_MAX);
    low_sum   = sub_sel ? ({1'b0, acc_lo} - LOW_FIX) : ({1'b0, acc_lo} + LOW_FIX);
    mid_val   = low_fire ? low_sum[DATA_W-1:0] : acc_lo;
    mid_carry = carry_in | (low_fire & low_sum[DATA_W]);
    aux_out   = low_fire | aux_in;
    high_fire = mid_carry || (mid_val > HIGH_LIMIT);
    if (high_fire) begin
      acc_out = sub_sel ? (mid_val - HIGH_FIX) : (mid_val + HIGH_FIX);
    end else begin
      acc_out = mid_val;
    end
    carry_out = mid_carry | high_fire;
  end

endmodule

// File: rtl/dadj_unpacked.sv
// Single-digit correction with a tens adjust into the high byte.
module dadj_unpacked #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [DATA_W-1:0] acc_hi,
  input  logic              sub_sel,
  input  logic              aux_in,
  output logic [DATA_W-1:0] lo_out,
  output logic [DATA_W-1:0] hi_out,
  output logic              adj_flag
);

  localparam int                LO_W      = DATA_W / 2;
  localparam logic [LO_W-1:0]   DIGIT_MAX = LO_W'(9);
  localparam logic [DATA_W-1:0] LOW_FIX   = DATA_W'(6);
  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);

  logic              fire;
  logic [DATA_W-1:0] lo_tmp;

  always_comb begin
    fire = aux_in || (acc_lo[LO_W-1:0] > DIGIT_MAX);
    if (fire) begin
      lo_tmp = sub_sel ? (acc_lo - LOW_FIX) : (acc_lo + LOW_FIX);
      hi_out = sub_sel ? (acc_hi - ONE) : (acc_hi + ONE);
    end else begin
      lo_tmp = acc_lo;
      hi_out = acc_hi;
    end
    lo_out   = {{(DATA_W-LO_W){1'b0}}, lo_tmp[LO_W-1:0]};
    adj_flag = fire;
  end

endmodule

// File: rtl/dadj_flags.sv
// Sign, zero and even-parity of a result byte.
module dadj_flags #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] value,
  output logic              sign_f,
  output logic              zero_f,
  output logic              parity_f
);

  always_comb begin
    sign_f   = value[DATA_W-1];
    zero_f   = (value == '0);
    parity_f = ~^value;
  end

endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit
  import dadj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] al_i,
  input  logic [DATA_W-1:0] ah_i,
  input  logic              cf_i,
  input  logic              af_i,
  input  logic              sf_i,
  input  logic              zf_i,
  input  logic              pf_i,
  output logic              out_valid,
  output logic [DATA_W-1:0] al_o,
  output logic [DATA_W-1:0] ah_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o
);

  localparam int LO_W = DATA_W / 2;

  // reset: asserted at once, released through two flops
  logic rst_meta_n, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  adj_mode_e mode_e;
  logic      sub_sel;
  assign mode_e  = adj_mode_e'(mode);
  assign sub_sel = mode[0];

  logic [DATA_W-1:0] pk_al;
  logic              pk_cf, pk_af;
  logic              pk_sf, pk_zf, pk_pf;
  logic [DATA_W-1:0] un_al, un_ah;
  logic              un_flag;

  dadj_packed #(.DATA_W(DATA_W)) u_packed (
    .acc_lo   (al_i),
    .sub_sel  (sub_sel),
    .carry_in (cf_i),
    .aux_in   (af_i),
    .acc_out  (pk_al),
    .carry_out(pk_cf),
    .aux_out  (pk_af)
  );

  dadj_flags #(.DATA_W(DATA_W)) u_flags (
    .value   (pk_al),
    .sign_f  (pk_sf),
    .zero_f  (pk_zf),
    .parity_f(pk_pf)
  );

  dadj_unpacked #(.DATA_W(DATA_W)) u_unpacked (
    .acc_lo  (al_i),
    .acc_hi  (ah_i),
    .sub_sel (sub_sel),
    .aux_in  (af_i),
    .lo_out  (un_al),
    .hi_out  (un_ah),
    .adj_flag(un_flag)
  );

  // next-state selection
  logic [DATA_W-1:0] nxt_al, nxt_ah;
  logic              nxt_cf, nxt_af, nxt_sf, nxt_zf, nxt_pf;

  always_comb begin
    unique case (mode_e)
      ADJ_PK_ADD, ADJ_PK_SUB: begin
        nxt_al = pk_al;
        nxt_ah = ah_i;
        nxt_cf = pk_cf;
        nxt_af = pk_af;
        nxt_sf = pk_sf;
        nxt_zf = pk_zf;
        nxt_pf = pk_pf;
      end
      default: begin
        nxt_al = un_al;
        nxt_ah = un_ah;
        nxt_cf = un_flag;
        nxt_af = un_flag;
        nxt_sf = sf_i;
        nxt_zf = zf_i;
        nxt_pf = pf_i;
      end
    endcase
  end

  // result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      al_o <= '0;
      ah_o <= '0;
      cf_o <= 1'b0;
      af_o <= 1'b0;
      sf_o <= 1'b0;
      zf_o <= 1'b0;
      pf_o <= 1'b0;
    end else if (in_valid) begin
      al_o <= nxt_al;
      ah_o <= nxt_ah;
      cf_o <= nxt_cf;
      af_o <= nxt_af;
      sf_o <= nxt_sf;
      zf_o <= nxt_zf;
      pf_o <= nxt_pf;
    end
  end

  // checks on the registered results against the captured request
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n) in_valid |=> out_valid); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_sync_n) !in_valid |=> !out_valid); // R10
  AST_PK_CARRY_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(!mode[1] && cf_i) |-> cf_o); // R2
  AST_PK_AUX_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(!mode[1] && af_i) |-> af_o); // R4
  AST_PK_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(!mode[1]) |-> (zf_o == (al_o == '0))); // R5
  AST_PK_AH_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(!mode[1]) |-> (ah_o == $past(ah_i))); // R5
  AST_UNPK_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(mode[1]) |-> (al_o[DATA_W-1:LO_W] == '0)); // R8
  AST_UNPK_CF_AF_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(mode[1]) |-> (cf_o == af_o)); // R6
  AST_UNPK_SZP_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n) out_valid && $past(mode[1]) |-> (sf_o == $past(sf_i) && zf_o == $past(zf_i) && pf_o == $past(pf_i))); // R9

endmodule

// File: tb/tb_dec_adjust_unit.sv
module tb_dec_adjust_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] al_i = 8'h00, ah_i = 8'h00;
  logic       cf_i = 1'b0, af_i = 1'b0, sf_i = 1'b0, zf_i = 1'b0, pf_i = 1'b0;
  logic       out_valid;
  logic [7:0] al_o, ah_o;
  logic       cf_o, af_o, sf_o, zf_o, pf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dec_adjust_unit #(.DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .al_i(al_i), .ah_i(ah_i), .cf_i(cf_i), .af_i(af_i),
    .sf_i(sf_i), .zf_i(zf_i), .pf_i(pf_i),
    .out_valid(out_valid), .al_o(al_o), .ah_o(ah_o),
    .cf_o(cf_o), .af_o(af_o), .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o)
  );

  typedef struct {
    int    al;
    int    ah;
    bit    cf;
    bit    af;
    bit    sf;
    bit    zf;
    bit    pf;
    string req;
  } exp_t;

  exp_t sb_q[$];

  function automatic bit even_ones(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  // reference built from the requirement text
  function automatic exp_t model(int md, int a, int h, bit c, bit x, bit s, bit z, bit p, string tag);
    exp_t e;
    int   t;
    bit   sub = md[0];
    e.req = tag;
    if (md < 2) begin
      e.af = x;
      if (x || (a % 16) > 9) begin
        t = sub ? a - 6 : a + 6;
        if (t < 0 || t > 255) c = 1'b1;
        a = t & 255;
        e.af = 1'b1;
      end
      if (c || a > 'h9F) begin
        a = (sub ? a - 'h60 : a + 'h60) & 255;
        c = 1'b1;
      end
      e.al = a; e.ah = h; e.cf = c;
      e.sf = a[7]; e.zf = (a == 0); e.pf = even_ones(a);
    end else begin
      if (x || (a % 16) > 9) begin
        a = sub ? a - 6 : a + 6;
        h = (sub ? h - 1 : h + 1) & 255;
        e.af = 1'b1; e.cf = 1'b1;
      end else begin
        e.af = 1'b0; e.cf = 1'b0;
      end
      e.al = a & 15; e.ah = h;
      e.sf = s; e.zf = z; e.pf = p;
    end
    return e;
  endfunction

  task automatic drive(int md, int a, int h, bit c, bit x, bit s, bit z, bit p, string tag);
    @(negedge clk);
    mode = md[1:0]; al_i = a[7:0]; ah_i = h[7:0];
    cf_i = c; af_i = x; sf_i = s; zf_i = z; pf_i = p;
    in_valid = 1'b1;
    sb_q.push_back(model(md, a, h, c, x, s, z, p, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: results are due one edge after the request
  initial begin
    exp_t e;
    bit   bad;
    forever begin
      @(negedge clk);
      if (out_valid && !done) begin
        checks++;
        if (sb_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected result: out_valid=%0b expected=0", out_valid);
        end else begin
          e = sb_q.pop_front();
          bad = 1'b0;
          if (al_o != e.al[7:0]) begin bad = 1'b1; $display("FAIL %s AL: actual=%02h expected=%02h", e.req, al_o, e.al[7:0]); end
          if (ah_o != e.ah[7:0]) begin bad = 1'b1; $display("FAIL %s AH: actual=%02h expected=%02h", e.req, ah_o, e.ah[7:0]); end
          if (cf_o != e.cf) begin bad = 1'b1; $display("FAIL %s CF: actual=%0b expected=%0b", e.req, cf_o, e.cf); end
          if (af_o != e.af) begin bad = 1'b1; $display("FAIL %s AF: actual=%0b expected=%0b", e.req, af_o, e.af); end
          if (sf_o != e.sf) begin bad = 1'b1; $display("FAIL %s SF: actual=%0b expected=%0b", e.req, sf_o, e.sf); end
          if (zf_o != e.zf) begin bad = 1'b1; $display("FAIL %s ZF: actual=%0b expected=%0b", e.req, zf_o, e.zf); end
          if (pf_o != e.pf) begin bad = 1'b1; $display("FAIL %s PF: actual=%0b expected=%0b", e.req, pf_o, e.pf); end
          if (bad) fails++;
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || al_o !== 8'h00 || ah_o !== 8'h00 || cf_o !== 1'b0 || af_o !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual=%0b/%02h/%02h expected=0/00/00", out_valid, al_o, ah_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(0, 'h0B, 'h33, 0, 0, 0, 0, 0, "R1");     // -> 11, AF=1
    drive(1, 'h2F, 'h00, 0, 0, 0, 0, 0, "R1");     // -> 29, AF=1
    drive(1, 'h03, 'h10, 0, 1, 0, 0, 0, "R2");     // bit 8 borrow -> 9D, CF=1
    drive(0, 'hFC, 'h00, 0, 0, 0, 0, 0, "R2");     // FC+6 carries -> 62, CF=1
    drive(0, 'h9A, 'h00, 0, 0, 0, 0, 0, "R3");     // A0 after step one -> 00, CF=1
    drive(0, 'h99, 'h00, 0, 0, 0, 0, 0, "R3");     // stays 99, CF=0
    drive(0, 'h45, 'h00, 0, 0, 0, 0, 0, "R4");     // no fire, AF stays 0
    drive(0, 'h30, 'h00, 0, 0, 1, 1, 1, "R5");     // parity even, sign 0
    drive(0, 'h07, 'h00, 0, 0, 0, 0, 0, "R5");     // odd parity
    drive(2, 'h0C, 'h02, 0, 0, 0, 0, 0, "R6");     // -> 02/03
    drive(3, 'h0B, 'h05, 0, 0, 0, 0, 0, "R6");     // -> 05/04
    drive(2, 'h35, 'h07, 1, 0, 0, 0, 0, "R7");     // no fire, CF cleared
    drive(3, 'hF9, 'h01, 0, 0, 0, 0, 0, "R8");     // high nibble cleared
    drive(2, 'h44, 'h00, 0, 0, 1, 0, 1, "R9");     // flags pass through
    drive(3, 'h02, 'h00, 0, 1, 0, 1, 0, "R11");    // AH 00-1 -> FF
    drive(2, 'h0F, 'hFF, 0, 0, 1, 1, 1, "R11");    // AH FF+1 -> 00
    idle();
    repeat (3) @(negedge clk);
    // R10: no result without a request
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle: actual=%0b expected=0", out_valid);
    end

    for (int md = 0; md < 4; md++) begin
      for (int a = 0; a < 256; a++) begin
        for (int fl = 0; fl < 4; fl++) begin
          drive(md, a, (a * 7 + md) & 255, fl[0], fl[1], a[0], a[1], a[2], "R1/R3/R5/R6/R8 sweep");
        end
      end
    end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R10 pending results: actual=%0d expected=0", sb_q.size());
    end
    finish_run();
  end

endmodule